// File: doc/BRIEF.md
# External Event Timestamp Capture Unit

This block samples a free-running time-of-day value (32-bit seconds, 30-bit nanoseconds) whenever a chosen input pin changes level, stores the value in a snapshot bank and raises an interrupt. Each logical capture channel can be routed to any of the physical pins. Rising and falling edges are enabled separately. Each polarity has its own snapshot bank and its own sticky status flag.

Software programs the unit through a 16-bit register port: the pin-to-channel routing, the edge enables, a channel selector for reads and a top-level interrupt gate. When the interrupt fires, software reads the snapshot words of the selected channel and then reads the status register. That read clears the flags. The time counter, pin direction control and the serial management bus live outside the block.

Top module: `evt_ts_capture`

## Requirements
- R1: Each pin passes through a two-flop synchronizer and an edge detector. A pin change driven before clock edge A records the time value present at edge A+2.
- R2: In the enable register (offset 0x233), bit c enables rising-edge capture for channel c and bit c+8 enables falling-edge capture. An edge whose enable bit is clear sets no flag and stores nothing.
- R3: A snapshot is read as four words: seconds high, seconds low, nanoseconds high and nanoseconds low. The seconds value is {high, low}. Only bits 13:0 of the nanoseconds high word carry data, and bits 15:14 read as zero.
- R4: The status register (offset 0x23D) holds the rising flag of channel c at bit c and the falling flag at bit c+8. A flag stays set until software clears it.
- R5: A read of the status register clears every flag. An enabled edge captured in the same cycle as that read leaves its flag set and stores its time.
- R6: While a bank's flag is set, further edges of that polarity on that channel do not change the bank.
- R7: Map register (offset 0x232) bits 4c+3:4c give the physical pin that feeds channel c. The value 0 disconnects the channel, so it records no events.
- R8: Select register (offset 0x230) bits 9:8 choose the channel whose snapshot words are read. Rising words are at offsets 0x235 to 0x238 and falling words at 0x239 to 0x23C, each in the order of R3.
- R9: irq_o is high exactly when bit 2 of the interrupt-enable register (offset 0x204) is set and at least one status flag is set.
- R10: The interrupt-enable, select, map and enable registers read back the last value written.
- R11: After reset all registers and flags are zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 16 | Asynchronous event pins |
| tod_sec_i | input | 32 | Time-of-day seconds |
| tod_ns_i | input | 30 | Time-of-day nanoseconds |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a status read clears the flags) |
| reg_addr_i | input | 12 | Register offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Capture interrupt |

## Verification
The assertions assume that a read strobe is the only way a status flag is cleared. They also assume that pins are low when reset is released, so that no spurious edge is captured. The stimulus drives every pin low during reset. Register writes, reads and pin changes are driven on the falling clock edge and held for a full cycle. Successive edges on a pin are spaced by at least the synchronizer depth, so every edge is counted exactly once.

// File: rtl/evt_ts_pkg.sv
package evt_ts_pkg;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 12;
  localparam int SEC_W    = 32;
  localparam int NS_W     = 30;
  localparam int MAP_W    = 4;
  localparam int FALL_OFS = 8;
  localparam int SEL_LSB  = 8;
  localparam int IRQ_BIT  = 2;

  localparam logic [ADDR_W-1:0] A_INT_EN   = 12'h204;
  localparam logic [ADDR_W-1:0] A_SEL      = 12'h230;
  localparam logic [ADDR_W-1:0] A_MAP      = 12'h232;
  localparam logic [ADDR_W-1:0] A_CAP_EN   = 12'h233;
  localparam logic [ADDR_W-1:0] A_R_SEC_HI = 12'h235;
  localparam logic [ADDR_W-1:0] A_R_SEC_LO = 12'h236;
  localparam logic [ADDR_W-1:0] A_R_NS_HI  = 12'h237;
  localparam logic [ADDR_W-1:0] A_R_NS_LO  = 12'h238;
  localparam logic [ADDR_W-1:0] A_F_SEC_HI = 12'h239;
  localparam logic [ADDR_W-1:0] A_F_SEC_LO = 12'h23A;
  localparam logic [ADDR_W-1:0] A_F_NS_HI  = 12'h23B;
  localparam logic [ADDR_W-1:0] A_F_NS_LO  = 12'h23C;
  localparam logic [ADDR_W-1:0] A_STS      = 12'h23D;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } stamp_t;
endpackage

// File: rtl/evt_ts_sync.sv
module evt_ts_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    logic              last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '0;
        last_q <= 1'b0;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], pins_i[p]};
        last_q <= sh_q[STAGES-1];
      end
    end
    assign rise_o[p] = sh_q[STAGES-1] & ~last_q;
    assign fall_o[p] = ~sh_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/evt_ts_channel.sv
module evt_ts_channel
  import evt_ts_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] fall_i,
  input  logic [MAP_W-1:0]    map_i,
  input  logic                en_rise_i,
  input  logic                en_fall_i,
  input  logic                clr_i,
  input  stamp_t              tod_i,
  output logic                flag_rise_o,
  output logic                flag_fall_o,
  output stamp_t              snap_rise_o,
  output stamp_t              snap_fall_o
);
  logic   connected;
  logic   [1:0] hit;
  logic   [1:0] flag_q;
  stamp_t bank_q [2];

  assign connected = (map_i != '0);
  assign hit[0]    = connected & en_rise_i & rise_i[map_i];
  assign hit[1]    = connected & en_fall_i & fall_i[map_i];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[b] <= 1'b0;
        bank_q[b] <= '0;
      end else begin
        // bank frozen while flagged, unless the flag is cleared this cycle
        if (hit[b] && (!flag_q[b] || clr_i)) bank_q[b] <= tod_i;
        flag_q[b] <= hit[b] | (flag_q[b] & ~clr_i);
      end
    end
  end

  assign flag_rise_o = flag_q[0];
  assign flag_fall_o = flag_q[1];
  assign snap_rise_o = bank_q[0];
  assign snap_fall_o = bank_q[1];
endmodule

// File: rtl/evt_ts_regs.sv
module evt_ts_regs
  import evt_ts_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  sts_i,
  input  stamp_t            snap_rise_i [NUM_CH],
  input  stamp_t            snap_fall_i [NUM_CH],
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_en_o,
  output logic [REG_W-1:0]  map_o,
  output logic [REG_W-1:0]  cap_en_o,
  output logic              sts_clr_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [REG_W-1:0] int_en_q, sel_q, map_q, cap_en_q;
  logic [CH_W-1:0]  ch;
  stamp_t           sr, sf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= '0;
      sel_q    <= '0;
      map_q    <= '0;
      cap_en_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_INT_EN: int_en_q <= wdata_i;
        A_SEL:    sel_q    <= wdata_i;
        A_MAP:    map_q    <= wdata_i;
        A_CAP_EN: cap_en_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ch = sel_q[SEL_LSB +: CH_W];

  always_comb begin
    sr = '0;
    sf = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch == CH_W'(c)) begin
        sr = snap_rise_i[c];
        sf = snap_fall_i[c];
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_INT_EN:   rdata_o = int_en_q;
      A_SEL:      rdata_o = sel_q;
      A_MAP:      rdata_o = map_q;
      A_CAP_EN:   rdata_o = cap_en_q;
      A_R_SEC_HI: rdata_o = sr.sec[SEC_W-1:16];
      A_R_SEC_LO: rdata_o = sr.sec[15:0];
      A_R_NS_HI:  rdata_o = REG_W'(sr.ns[NS_W-1:16]);
      A_R_NS_LO:  rdata_o = sr.ns[15:0];
      A_F_SEC_HI: rdata_o = sf.sec[SEC_W-1:16];
      A_F_SEC_LO: rdata_o = sf.sec[15:0];
      A_F_NS_HI:  rdata_o = REG_W'(sf.ns[NS_W-1:16]);
      A_F_NS_LO:  rdata_o = sf.ns[15:0];
      A_STS:      rdata_o = sts_i;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_en_o  = int_en_q[IRQ_BIT];
  assign map_o     = map_q;
  assign cap_en_o  = cap_en_q;
  assign sts_clr_o = rd_i && (addr_i == A_STS);
endmodule

// File: rtl/evt_ts_capture.sv
module evt_ts_capture
  import evt_ts_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_CH   = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [SEC_W-1:0]    tod_sec_i,
  input  logic [NS_W-1:0]     tod_ns_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] rise_w, fall_w;
  logic [REG_W-1:0]    map_w, cap_en_w, sts_w;
  logic [NUM_CH-1:0]   fr_w, ff_w;
  logic                irq_en_w, clr_w;
  stamp_t              tod_w;
  stamp_t              snap_rise_w [NUM_CH];
  stamp_t              snap_fall_w [NUM_CH];

  assign tod_w = '{sec: tod_sec_i, ns: tod_ns_i};

  evt_ts_sync #(.NUM_PINS(NUM_PINS), .STAGES(STAGES)) i_sync (
    .clk_i, .rst_ni, .pins_i, .rise_o(rise_w), .fall_o(fall_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evt_ts_channel #(.NUM_PINS(NUM_PINS)) i_ch (
      .clk_i, .rst_ni,
      .rise_i      (rise_w),
      .fall_i      (fall_w),
      .map_i       (map_w[MAP_W*c +: MAP_W]),
      .en_rise_i   (cap_en_w[c]),
      .en_fall_i   (cap_en_w[FALL_OFS+c]),
      .clr_i       (clr_w),
      .tod_i       (tod_w),
      .flag_rise_o (fr_w[c]),
      .flag_fall_o (ff_w[c]),
      .snap_rise_o (snap_rise_w[c]),
      .snap_fall_o (snap_fall_w[c])
    );
  end

  always_comb begin
    sts_w = '0;
    sts_w[NUM_CH-1:0]          = fr_w;
    sts_w[FALL_OFS +: NUM_CH]  = ff_w;
  end

  evt_ts_regs #(.NUM_CH(NUM_CH)) i_regs (
    .clk_i, .rst_ni,
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .sts_i       (sts_w),
    .snap_rise_i (snap_rise_w),
    .snap_fall_i (snap_fall_w),
    .rdata_o     (reg_rdata_o),
    .irq_en_o    (irq_en_w),
    .map_o       (map_w),
    .cap_en_o    (cap_en_w),
    .sts_clr_o   (clr_w)
  );

  assign irq_o = irq_en_w & (|sts_w);
endmodule

// File: rtl/evt_ts_capture_chk.sv
module evt_ts_capture_chk
  import evt_ts_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              irq_o,
  input logic              irq_en_i,
  input logic [REG_W-1:0]  sts_i,
  input stamp_t            snap0_i
);
  logic sts_rd;
  assign sts_rd = reg_rd_i && (reg_addr_i == A_STS);

  // R4: without a status read no flag drops
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_rd |=> ((sts_i & $past(sts_i)) == $past(sts_i)));

  // R6: flagged channel-0 rising bank stays frozen
  a_r6_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[0] && !sts_rd) |=> $stable(snap0_i));

  // R9: interrupt gated by enable bit
  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  // R9: interrupt implies a pending flag
  a_r9_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_i != '0));

  // R3: unused nanosecond-high bits read zero
  a_r3_ns_hi_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_R_NS_HI || reg_addr_i == A_F_NS_HI) |-> (reg_rdata_o[15:14] == 2'b00));
endmodule

bind evt_ts_capture evt_ts_capture_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .irq_en_i    (irq_en_w),
  .sts_i       (sts_w),
  .snap0_i     (snap_rise_w[0])
);

// File: tb/test_evt_ts_capture.sv
module test_evt_ts_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic [31:0] tod_sec;
  logic [29:0] tod_ns;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int unsigned cyc = 0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam logic [11:0] R_IEN = 12'h204, R_SEL = 12'h230, R_MAP = 12'h232,
                          R_EN = 12'h233, R_STS = 12'h23D;

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] sec_of(int unsigned c); return c * 3 + 32'h0001_0000; endfunction
  function automatic logic [29:0] ns_of(int unsigned c);  return 30'(c * 7 + 100); endfunction
  assign tod_sec = sec_of(cyc);
  assign tod_ns  = ns_of(cyc);

  evt_ts_capture i_evt_ts_capture (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .tod_sec_i(tod_sec), .tod_ns_i(tod_ns),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [11:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [11:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic edge_ev(int p, logic v, output int unsigned c);
    @(negedge clk); pins[p] = v;
    @(negedge clk);
    @(negedge clk); #1 c = cyc;
    @(negedge clk);
  endtask

  task automatic chk_snap(string req, int ch, bit fall, int unsigned c);
    logic [15:0] sh, sl, nh, nl;
    logic [11:0] b;
    b = fall ? 12'h239 : 12'h235;
    wreg(R_SEL, 16'(ch << 8));
    rreg(b, sh); rreg(b + 1, sl); rreg(b + 2, nh); rreg(b + 3, nl);
    chk(req, {sh, sl}, sec_of(c));
    chk(req, {2'b00, nh[13:0], nl}, 32'(ns_of(c)));
    chk("R3", 32'(nh[15:14]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int unsigned c1, c2, cf, ch0_last;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11", 32'(irq), 0);
    rreg(R_IEN, d); chk("R11", 32'(d), 0);
    rreg(R_MAP, d); chk("R11", 32'(d), 0);
    rreg(R_EN, d);  chk("R11", 32'(d), 0);
    rreg(R_STS, d); chk("R11", 32'(d), 0);

    // R10 readback
    wreg(R_IEN, 16'h0004); rreg(R_IEN, d); chk("R10", 32'(d), 32'h0004);
    wreg(R_MAP, 16'h0005); rreg(R_MAP, d); chk("R10", 32'(d), 32'h0005);
    wreg(R_EN, 16'h0001);  rreg(R_EN, d);  chk("R10", 32'(d), 32'h0001);
    wreg(R_SEL, 16'h0300); rreg(R_SEL, d); chk("R10", 32'(d), 32'h0300);

    // R1 R4 R9: rising capture on pin 5 -> channel 0
    edge_ev(5, 1'b1, c1);
    chk("R9", 32'(irq), 1);
    chk_snap("R1", 0, 1'b0, c1);
    rreg(R_STS, d); chk("R4", 32'(d), 32'h0001);
    rreg(R_STS, d); chk("R5", 32'(d), 32'h0000);
    chk("R9", 32'(irq), 0);

    // R2 falling edge disabled
    edge_ev(5, 1'b0, cf);
    rreg(R_STS, d); chk("R2", 32'(d), 32'h0000);

    // R2 R6: both edges enabled, later edges dropped while flagged
    wreg(R_EN, 16'h0101);
    edge_ev(5, 1'b1, c1);
    edge_ev(5, 1'b0, cf);
    edge_ev(5, 1'b1, c2);
    edge_ev(5, 1'b0, c2);
    chk_snap("R6", 0, 1'b0, c1);
    chk_snap("R2", 0, 1'b1, cf);
    rreg(R_STS, d); chk("R4", 32'(d), 32'h0101);

    // R5 edge in the same cycle as the status read
    wreg(R_EN, 16'h0001);
    edge_ev(5, 1'b1, c1);
    edge_ev(5, 1'b0, cf);
    @(negedge clk); pins[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = R_STS; rd = 1'b1; #1 c2 = cyc; d = rdata;
    @(negedge clk); rd = 1'b0;
    chk("R5", 32'(d), 32'h0001);
    chk_snap("R5", 0, 1'b0, c2);
    rreg(R_STS, d); chk("R5", 32'(d), 32'h0001);
    edge_ev(5, 1'b0, cf);

    // R9 interrupt gate
    wreg(R_IEN, 16'h0000);
    edge_ev(5, 1'b1, ch0_last);
    chk("R9", 32'(irq), 0);
    wreg(R_IEN, 16'h0004);
    chk("R9", 32'(irq), 1);
    rreg(R_STS, d); chk("R4", 32'(d), 32'h0001);
    edge_ev(5, 1'b0, cf);

    // R7 unmapped channel records nothing
    wreg(R_MAP, 16'h0000);
    edge_ev(5, 1'b1, c1);
    edge_ev(5, 1'b0, c1);
    rreg(R_STS, d); chk("R7", 32'(d), 32'h0000);

    // R7 R8: channel 1 on pin 9, select between channels
    wreg(R_MAP, 16'h0090); wreg(R_EN, 16'h0002);
    edge_ev(9, 1'b1, c1);
    edge_ev(9, 1'b0, cf);
    rreg(R_STS, d); chk("R7", 32'(d), 32'h0002);
    chk_snap("R8", 1, 1'b0, c1);
    chk_snap("R8", 0, 1'b0, ch0_last);

    // random: channel, pin, enables
    for (int i = 0; i < 30; i++) begin
      int ch, p, gap;
      bit er, ef;
      int unsigned cr, cfl;
      ch  = int'($urandom_range(3, 0));
      p   = int'($urandom_range(15, 1));
      er  = 1'($urandom_range(1, 0));
      ef  = 1'($urandom_range(1, 0));
      gap = int'($urandom_range(5, 0));
      wreg(R_MAP, 16'(p << (4 * ch)));
      wreg(R_EN, 16'((32'(er) << ch) | (32'(ef) << (ch + 8))));
      edge_ev(p, 1'b1, cr);
      repeat (gap) @(negedge clk);
      edge_ev(p, 1'b0, cfl);
      if (er) chk_snap("R1", ch, 1'b0, cr);
      if (ef) chk_snap("R2", ch, 1'b1, cfl);
      rreg(R_STS, d);
      chk("R4", 32'(d), (32'(er) << ch) | (32'(ef) << (ch + 8)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule